// File: doc/BRIEF.md
# Addressed Peripheral Port Unit

This unit sits between a processor bus and one simple peripheral. Every bus cycle carries an 8-bit device address and a 2-bit command field. The unit acts only when the address equals its own identifier. It accepts four command classes. A control command directs the peripheral and selects how the unit reports completion. A test command returns a status word. A read command fetches one item from the peripheral into an internal data register. A write command sends one bus word to the peripheral.

Read data does not appear on the bus when the fetch completes. The processor collects it later with a separate data-request strobe, which uses the same address match. The unit has two ways to report completion. In polled mode it only updates its status bits, and the processor must poll them. In interrupt mode it also holds an interrupt line high while unread data sits in the data register.

Top module: `pio_unit`

## Requirements
- R1: A command or data request whose address differs from `MY_ADDR` (default 0x5A) is ignored. It produces no bus response, no control strobe and no device request, and it changes no status.
- R2: The command field is encoded as 00 control, 01 test, 10 read, 11 write. An accepted control command drives `bus_wdata[DATA_W-1:1]` onto `dev_ctrl` and pulses `dev_ctrl_stb` for one cycle, both visible in the cycle after the command. `bus_wdata[0]` selects interrupt mode (1) or polled mode (0).
- R3: A test command produces `bus_rvalid` one cycle later with the status word in the low bits of `bus_rdata`. The layout is: bit0 device present, bit1 busy, bit2 last operation done, bit3 read data ready, bit4 error, bit5 interrupt mode. The upper bits are zero. The test also clears the error bit once it has been reported.
- R4: An accepted read raises `dev_rd_req` in the next cycle and holds it until `dev_rd_ack`. On the ack the unit latches `dev_rd_data`, sets ready and done, and clears busy.
- R5: A data request returns the data register on `bus_rdata` with `bus_rvalid` one cycle later and clears the ready bit.
- R6: An accepted write latches `bus_wdata` onto `dev_wr_data` and holds `dev_wr_req` until `dev_wr_ack`. Done is set on the ack.
- R7: In polled mode `irq` stays low.
- R8: In interrupt mode `irq` is high while read data is ready. It stays high until the data request.
- R9: While a read or write is in progress, any control, read or write command is rejected without effect, and the error bit is set.
- R10: The error bit is set when `dev_err` accompanies a device ack. It is also set when a read or write is issued while the device is absent; no device request is raised in that case.
- R11: After reset all status bits are clear, the unit is in polled mode, and no request, strobe, response or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Command cycle strobe |
| bus_addr | input | ADDR_W | Device address of the cycle |
| bus_cmd | input | 2 | Command class |
| bus_wdata | input | DATA_W | Write or control word |
| bus_dreq | input | 1 | Data request strobe (uses bus_addr) |
| bus_rvalid | output | 1 | Response valid |
| bus_rdata | output | DATA_W | Status or read data |
| irq | output | 1 | Interrupt, held while data is ready in interrupt mode |
| dev_present | input | 1 | Peripheral available |
| dev_ctrl | output | DATA_W-1 | Control word to the peripheral |
| dev_ctrl_stb | output | 1 | One-cycle control strobe |
| dev_rd_req | output | 1 | Fetch request to the peripheral |
| dev_rd_ack | input | 1 | Fetch complete |
| dev_rd_data | input | DATA_W | Fetched item |
| dev_wr_req | output | 1 | Send request to the peripheral |
| dev_wr_data | output | DATA_W | Word to send |
| dev_wr_ack | input | 1 | Send complete |
| dev_err | input | 1 | Error flag, sampled with an ack |

## Verification
The properties assume three things about the bus. `bus_valid` and `bus_dreq` are never high in the same cycle. The device acks only while its matching request is high. Acks never coincide with a new command to the unit. The bench drives every bus cycle through one task that raises a single strobe for one cycle. The device model acks only an outstanding request, after a programmable delay. Commands sent during a transfer are placed well inside that delay.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        CMD_CTRL  = 2'b00,
        CMD_TEST  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } pio_cmd_e;

    // one-hot classification of an addressed bus cycle
    typedef struct packed {
        logic ctrl;
        logic test;
        logic rd;
        logic wr;
        logic dreq;
    } pio_hit_t;

    // status word, LSB first: present, busy, done, ready, err, irq mode
    typedef struct packed {
        logic irq_en;
        logic err;
        logic ready;
        logic done;
        logic busy;
        logic avail;
    } pio_stat_t;

    localparam int STAT_W = $bits(pio_stat_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR
    } pio_state_e;

    function automatic logic in_transfer(pio_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MY_ADDR = 8'h5A
) (
    input  logic              bus_valid,
    input  logic              bus_dreq,
    input  logic [ADDR_W-1:0] bus_addr,
    input  pio_cmd_e          bus_cmd,
    output pio_hit_t          hit
);
    logic sel;
    assign sel = (bus_addr == MY_ADDR);

    always_comb begin
        hit = '0;
        if (sel && bus_valid) begin
            case (bus_cmd)
                CMD_CTRL:  hit.ctrl = 1'b1;
                CMD_TEST:  hit.test = 1'b1;
                CMD_READ:  hit.rd   = 1'b1;
                CMD_WRITE: hit.wr   = 1'b1;
                default:   hit      = '0;
            endcase
        end
        hit.dreq = sel && bus_dreq;
    end
endmodule

// File: rtl/pio_engine.sv
module pio_engine
    import pio_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CTRL_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  pio_hit_t          hit,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dev_present,
    input  logic              dev_rd_ack,
    input  logic [DATA_W-1:0] dev_rd_data,
    input  logic              dev_wr_ack,
    input  logic              dev_err,
    output logic              dev_rd_req,
    output logic              dev_wr_req,
    output logic [DATA_W-1:0] dev_wr_data,
    output logic [CTRL_W-1:0] dev_ctrl,
    output logic              dev_ctrl_stb,
    output logic [DATA_W-1:0] rd_data,
    output pio_stat_t         stat
);
    pio_state_e state;
    logic irq_en, ready, done, err;
    logic busy, start_rd, start_wr, rd_done, wr_done, ctrl_take, err_set;

    assign busy      = in_transfer(state);
    assign start_rd  = !busy && hit.rd && dev_present;
    assign start_wr  = !busy && hit.wr && dev_present;
    assign rd_done   = (state == ST_RD) && dev_rd_ack;
    assign wr_done   = (state == ST_WR) && dev_wr_ack;
    assign ctrl_take = !busy && hit.ctrl;
    assign err_set   = (busy && (hit.ctrl || hit.rd || hit.wr))
                     || (!busy && (hit.rd || hit.wr) && !dev_present)
                     || ((rd_done || wr_done) && dev_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            rd_data      <= '0;
            dev_wr_data  <= '0;
            dev_ctrl     <= '0;
            dev_ctrl_stb <= 1'b0;
            irq_en       <= 1'b0;
            ready        <= 1'b0;
            done         <= 1'b0;
            err          <= 1'b0;
        end else begin
            dev_ctrl_stb <= ctrl_take;
            if (ctrl_take) begin
                dev_ctrl <= bus_wdata[DATA_W-1:1];
                irq_en   <= bus_wdata[0];
            end
            if (start_rd) begin
                state <= ST_RD;
            end else if (start_wr) begin
                state       <= ST_WR;
                dev_wr_data <= bus_wdata;
            end else if (rd_done || wr_done) begin
                state <= ST_IDLE;
            end
            if (rd_done) rd_data <= dev_rd_data;
            done  <= (done && !(start_rd || start_wr)) || rd_done || wr_done;
            ready <= (ready && !hit.dreq) || rd_done;
            err   <= (err && !hit.test) || err_set;
        end
    end

    assign dev_rd_req = (state == ST_RD);
    assign dev_wr_req = (state == ST_WR);

    always_comb begin
        stat.irq_en = irq_en;
        stat.err    = err;
        stat.ready  = ready;
        stat.done   = done;
        stat.busy   = busy;
        stat.avail  = dev_present;
    end
endmodule

// File: rtl/pio_unit.sv
module pio_unit
    import pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MY_ADDR = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_cmd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_dreq,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              dev_present,
    output logic [DATA_W-2:0] dev_ctrl,
    output logic              dev_ctrl_stb,
    output logic              dev_rd_req,
    input  logic              dev_rd_ack,
    input  logic [DATA_W-1:0] dev_rd_data,
    output logic              dev_wr_req,
    output logic [DATA_W-1:0] dev_wr_data,
    input  logic              dev_wr_ack,
    input  logic              dev_err
);
    pio_hit_t          hit;
    pio_stat_t         stat;
    logic [DATA_W-1:0] rd_data;

    pio_decode #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_decode (
        .bus_valid (bus_valid),
        .bus_dreq  (bus_dreq),
        .bus_addr  (bus_addr),
        .bus_cmd   (pio_cmd_e'(bus_cmd)),
        .hit       (hit)
    );

    pio_engine #(.DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .bus_wdata    (bus_wdata),
        .dev_present  (dev_present),
        .dev_rd_ack   (dev_rd_ack),
        .dev_rd_data  (dev_rd_data),
        .dev_wr_ack   (dev_wr_ack),
        .dev_err      (dev_err),
        .dev_rd_req   (dev_rd_req),
        .dev_wr_req   (dev_wr_req),
        .dev_wr_data  (dev_wr_data),
        .dev_ctrl     (dev_ctrl),
        .dev_ctrl_stb (dev_ctrl_stb),
        .rd_data      (rd_data),
        .stat         (stat)
    );

    // response path: status or data register, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= hit.test || hit.dreq;
            bus_rdata  <= hit.dreq ? rd_data : DATA_W'(stat);
        end
    end

    assign irq = stat.irq_en && stat.ready;
endmodule

// File: rtl/pio_checks.sv
module pio_checks
    import pio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MY_ADDR = 8'h5A
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_dreq,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_cmd,
    input logic              bus_rvalid,
    input logic              dev_ctrl_stb,
    input logic              dev_rd_req,
    input logic              dev_rd_ack,
    input logic              dev_wr_req,
    input logic              dev_wr_ack,
    input logic              irq,
    input pio_stat_t         stat
);
    logic mine;
    assign mine = (bus_addr == MY_ADDR);

    assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid || bus_dreq) && !mine |=> !bus_rvalid && !dev_ctrl_stb);

    assert_rd_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        dev_rd_req && !dev_rd_ack |=> dev_rd_req);

    assert_wr_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        dev_wr_req && !dev_wr_ack |=> dev_wr_req);

    assert_dreq_clears_ready_R5: assert property (@(posedge clk) disable iff (rst)
        bus_dreq && mine && !dev_rd_ack |=> !stat.ready && !irq);

    assert_irq_held_R8: assert property (@(posedge clk) disable iff (rst)
        irq && !(bus_dreq && mine) && !(bus_valid && mine && bus_cmd == 2'b00)
        |=> irq);

    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (rst)
        dev_rd_req && !dev_rd_ack && bus_valid && mine && bus_cmd == 2'b11
        |=> !dev_wr_req && stat.err);
endmodule

bind pio_unit pio_checks #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_dreq     (bus_dreq),
    .bus_addr     (bus_addr),
    .bus_cmd      (bus_cmd),
    .bus_rvalid   (bus_rvalid),
    .dev_ctrl_stb (dev_ctrl_stb),
    .dev_rd_req   (dev_rd_req),
    .dev_rd_ack   (dev_rd_ack),
    .dev_wr_req   (dev_wr_req),
    .dev_wr_ack   (dev_wr_ack),
    .irq          (irq),
    .stat         (stat)
);

// File: tb/tb_pio_unit.sv
module tb_pio_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam logic [7:0] ME = 8'h5A;
    localparam logic [7:0] OTHER = 8'h11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_dreq = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [1:0] bus_cmd = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_rvalid, irq, dev_ctrl_stb, dev_rd_req, dev_wr_req;
    logic [DW-1:0] bus_rdata, dev_wr_data;
    logic [DW-2:0] dev_ctrl;
    logic dev_present = 1'b1, dev_rd_ack = 1'b0, dev_wr_ack = 1'b0, dev_err = 1'b0;
    logic [DW-1:0] dev_rd_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_unit dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_dreq(bus_dreq),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq),
        .dev_present(dev_present), .dev_ctrl(dev_ctrl), .dev_ctrl_stb(dev_ctrl_stb),
        .dev_rd_req(dev_rd_req), .dev_rd_ack(dev_rd_ack), .dev_rd_data(dev_rd_data),
        .dev_wr_req(dev_wr_req), .dev_wr_data(dev_wr_data), .dev_wr_ack(dev_wr_ack),
        .dev_err(dev_err)
    );

    int tests = 0, fails = 0;

    typedef struct {
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    bit exp_irq_en = 1'b0;
    int dev_delay = 2;
    bit dev_err_flag = 1'b0;
    logic [DW-1:0] next_item = '0;
    logic [DW-1:0] last_wr = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [1:0] cmd, input logic [7:0] addr,
                             input logic [DW-1:0] wd, input bit is_dreq);
        @(negedge clk);
        bus_addr  = addr;
        bus_cmd   = cmd;
        bus_wdata = wd;
        bus_valid = !is_dreq;
        bus_dreq  = is_dreq;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_dreq  = 1'b0;
    endtask

    // command field: 00 control, 01 test, 10 read, 11 write
    task automatic do_test(input logic [DW-1:0] exp_status, input string tag);
        exp_q.push_back('{exp_status, tag});
        bus_cycle(2'b01, ME, '0, 1'b0);
        @(negedge clk);
    endtask

    task automatic do_dreq(input logic [DW-1:0] exp_data, input string tag);
        exp_q.push_back('{exp_data, tag});
        bus_cycle(2'b00, ME, '0, 1'b1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && (dev_rd_req || dev_wr_req); i++) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected response", {16'h0, bus_rdata}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(bus_rdata == e.data, e.tag, {16'h0, bus_rdata}, {16'h0, e.data});
            end
        end
        if (!rst && !exp_irq_en && irq)
            check(1'b0, "R7 irq in polled mode", 32'h1, 32'h0);
    end

    // peripheral model
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            dev_rd_ack = 1'b0;
            dev_wr_ack = 1'b0;
            dev_err    = 1'b0;
            if (dev_rd_req || dev_wr_req) begin
                if (cnt >= dev_delay) begin
                    cnt = 0;
                    dev_err = dev_err_flag;
                    if (dev_rd_req) begin
                        dev_rd_ack  = 1'b1;
                        dev_rd_data = next_item;
                    end else begin
                        dev_wr_ack = 1'b1;
                        last_wr    = dev_wr_data;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!bus_rvalid && !irq && !dev_rd_req && !dev_wr_req && !dev_ctrl_stb,
              "R11 reset outputs", {27'h0, bus_rvalid, irq, dev_rd_req, dev_wr_req, dev_ctrl_stb}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        do_test(16'h0001, "R3 R11 status after reset");

        // R2 control, polled mode
        bus_cycle(2'b00, ME, {15'h2B, 1'b0}, 1'b0);
        check(dev_ctrl_stb && dev_ctrl == 15'h2B, "R2 control word",
              {16'h0, dev_ctrl_stb, dev_ctrl}, {16'h0, 1'b1, 15'h2B});
        @(negedge clk);
        check(!dev_ctrl_stb, "R2 strobe single cycle", {31'h0, dev_ctrl_stb}, 32'h0);

        // R4 polled read
        next_item = 16'h1234;
        bus_cycle(2'b10, ME, '0, 1'b0);
        check(dev_rd_req, "R4 read request raised", {31'h0, dev_rd_req}, 32'h1);
        wait_idle();
        check(!irq, "R7 no irq after polled read", {31'h0, irq}, 32'h0);
        do_test(16'h000D, "R3 R4 status ready+done");
        do_dreq(16'h1234, "R5 read data");
        do_test(16'h0005, "R5 ready cleared");

        // R6 write
        bus_cycle(2'b11, ME, 16'hBEEF, 1'b0);
        check(dev_wr_req && dev_wr_data == 16'hBEEF, "R6 write request",
              {15'h0, dev_wr_req, dev_wr_data}, {15'h0, 1'b1, 16'hBEEF});
        wait_idle();
        check(last_wr == 16'hBEEF, "R6 device received word", {16'h0, last_wr}, 32'hBEEF);
        do_test(16'h0005, "R6 status done");

        // R1 foreign address
        bus_cycle(2'b01, OTHER, '0, 1'b0);
        bus_cycle(2'b00, OTHER, 16'hFFFF, 1'b0);
        check(!dev_ctrl_stb && dev_ctrl == 15'h2B, "R1 foreign control ignored",
              {16'h0, dev_ctrl_stb, dev_ctrl}, {16'h0, 1'b0, 15'h2B});
        bus_cycle(2'b10, OTHER, '0, 1'b0);
        check(!dev_rd_req, "R1 foreign read ignored", {31'h0, dev_rd_req}, 32'h0);
        bus_cycle(2'b00, OTHER, '0, 1'b1);
        @(negedge clk);
        do_test(16'h0005, "R1 status unchanged");

        // R8 interrupt mode
        bus_cycle(2'b00, ME, {15'h01, 1'b1}, 1'b0);
        exp_irq_en = 1'b1;
        next_item = 16'h0A5C;
        bus_cycle(2'b10, ME, '0, 1'b0);
        check(!irq, "R8 irq low while fetching", {31'h0, irq}, 32'h0);
        wait_idle();
        check(irq, "R8 irq on ready", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        do_test(16'h002D, "R3 R8 status interrupt mode");
        check(irq, "R8 irq held until data request", {31'h0, irq}, 32'h1);
        do_dreq(16'h0A5C, "R5 R8 read data");
        check(!irq, "R8 irq cleared by data request", {31'h0, irq}, 32'h0);

        // R9 busy rejection
        dev_delay = 8;
        next_item = 16'h4321;
        bus_cycle(2'b10, ME, '0, 1'b0);
        bus_cycle(2'b11, ME, 16'h7777, 1'b0);
        check(dev_rd_req && !dev_wr_req, "R9 write rejected while busy",
              {30'h0, dev_rd_req, dev_wr_req}, 32'h2);
        bus_cycle(2'b00, ME, 16'hFFFE, 1'b0);
        check(!dev_ctrl_stb && dev_ctrl == 15'h01, "R9 control rejected while busy",
              {16'h0, dev_ctrl_stb, dev_ctrl}, {16'h0, 1'b0, 15'h01});
        wait_idle();
        dev_delay = 2;
        do_test(16'h003D, "R9 error set, mode kept");
        do_test(16'h002D, "R3 error cleared by test");
        do_dreq(16'h4321, "R9 original read data");
        @(negedge clk);

        // R10 device error and absent device
        dev_err_flag = 1'b1;
        bus_cycle(2'b11, ME, 16'h0F0F, 1'b0);
        wait_idle();
        dev_err_flag = 1'b0;
        do_test(16'h0035, "R10 device error reported");
        dev_present = 1'b0;
        bus_cycle(2'b10, ME, '0, 1'b0);
        check(!dev_rd_req, "R10 no request to absent device", {31'h0, dev_rd_req}, 32'h0);
        repeat (2) @(negedge clk);
        do_test(16'h0034, "R10 absent device error");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule